// File: doc/BRIEF.md
# Display Prefetch Control Register Bank

This block is the control and status register bank that sits in front of a display prefetch engine. Software reaches it through a simple 32-bit memory-mapped bus with a write strobe and a combinational read port. Every control register can be written in four ways. A plain write replaces the value. Three alias addresses beside it set, clear or invert only the bits written as 1, so software can change individual bits without a read-modify-write sequence.

The bank holds a system control word. Its run bit clears itself and produces a one-cycle start pulse. It also has a soft reset, a repeat flag, a master-ID flag and two shadow-load bits. An eight-source interrupt unit has a mask, a raw status view and a masked status view, and drives one level interrupt. A shadow scheme copies the programmed frame settings (control word, width, height) into active copies. On the first frame the copy follows the software start. After that it follows hardware frame events. A line-buffer control word drives its threshold and mode fields straight out to the fetch side.

Top module: `pfc_regs`

## Requirements
- R1: After reset the system word reads 0, the mask reads 0xFF, both status views read 0, all frame and line-buffer registers read 0, the active copies are 0, and `irq` and `start_pulse` are 0.
- R2: A plain write at a register's base offset replaces its writable bits. These are bits 4:0 and 16 of the system word at 0x000, bits 7:0 of the mask at 0x020, all 32 bits of the frame word at 0x070, bits 15:0 of width at 0x0A0 and height at 0x0B0, and bits 7:0 of the line-buffer word at 0x200.
- R3: A write at base+0x4 ORs the data into the register, one at base+0x8 clears the bits written as 1, and one at base+0xC inverts them. A read at any of the three aliases returns the register's value.
- R4: Writing 1 to system bit 0 (run) makes it read 1 for exactly the next cycle. `start_pulse` is high during that same cycle, and then both return to 0.
- R5: A one-cycle pulse on `evt_in[i]` sets raw status bit i at the next edge. The raw view at 0x040 shows status regardless of the mask. Status bit 1 is also set by the start pulse and bit 2 by every shadow copy.
- R6: The masked view at 0x030 returns raw AND NOT mask (a mask bit of 1 disables the source). `irq` is high whenever any masked bit is set.
- R7: A plain write at 0x030 clears each raw status bit written as 1 and leaves the bits written as 0. An event arriving in the same cycle as its clear wins.
- R8: With system bit 3 (shadow enable) and bit 4 (software select) both 1, the active copies take the programmed frame, width and height values at the edge that ends the start-pulse cycle, and `frame_evt` is ignored.
- R9: With shadow enable 1 and software select 0, a `frame_evt` pulse loads the active copies and the start pulse does not. With shadow enable 0, neither loads them.
- R10: While system bit 1 (soft reset) is 1, both status views and the active copies are forced to 0 from the next edge on and events are ignored. Programmed registers keep their values.
- R11: Reads of unmapped offsets return 0 and writes to them change nothing. This includes 0x040 and the alias offsets of 0x030 and 0x040.
- R12: Line-buffer bit 7 drives `rt_abort_sel`, bits 6:4 drive `rt_thr_low`, bits 3:1 drive `rt_thr_high` and bit 0 drives `rt_rows_sel`. System bits 1, 2 and 16 drive `ctl_soft_rst`, `ctl_repeat` and `ctl_master_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_in | input | 8 | Single-cycle event pulses, one per status bit |
| frame_evt | input | 1 | Hardware frame boundary pulse for shadow loads |
| irq | output | 1 | Level interrupt |
| start_pulse | output | 1 | One-cycle start from the run bit |
| ctl_repeat | output | 1 | Repeat flag |
| ctl_soft_rst | output | 1 | Soft reset flag |
| ctl_master_id | output | 1 | Bus master-ID control flag |
| act_frame | output | 32 | Active frame control word |
| act_xsize | output | 16 | Active width |
| act_ysize | output | 16 | Active height |
| rt_abort_sel | output | 1 | Line-buffer abort-versus-stall select |
| rt_thr_low | output | 3 | Line-buffer low threshold |
| rt_thr_high | output | 3 | Line-buffer high threshold |
| rt_rows_sel | output | 1 | Line-buffer active-row count select |

## Verification
The bench builds the bank with its default 12-bit address, so the whole map is reachable. This includes the line-buffer word at 0x200, unmapped holes such as 0x100, and the alias offsets of the status registers. With all eight status sources present, the bench can mix masked and unmasked events in one pattern and collide an event with its own clear. It can also walk the shadow scheme through software mode, hardware mode, disabled mode and soft reset.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    localparam int BUS_W   = 32;
    localparam int NUM_SRC = 8;
    localparam int SIZE_W  = 16;
    localparam int RT_W    = 8;

    // status source groups
    localparam logic [NUM_SRC-1:0] GRP_ERRORS  = 8'hF8;
    localparam logic [NUM_SRC-1:0] GRP_CONTROL = 8'h07;
    localparam int ST_DONE  = 0;
    localparam int ST_RUN   = 1;
    localparam int ST_SHLD  = 2;

    // system word bit positions
    localparam int SYS_RUN    = 0;
    localparam int SYS_SRST   = 1;
    localparam int SYS_REPEAT = 2;
    localparam int SYS_SHEN   = 3;
    localparam int SYS_SWSEL  = 4;
    localparam int SYS_MID    = 16;
    localparam logic [BUS_W-1:0] SYS_WMASK = 32'h0001_001F;

    // base offsets
    localparam logic [11:0] OFS_SYS   = 12'h000;
    localparam logic [11:0] OFS_MASK  = 12'h020;
    localparam logic [11:0] OFS_PEND  = 12'h030;
    localparam logic [11:0] OFS_RAW   = 12'h040;
    localparam logic [11:0] OFS_FRAME = 12'h070;
    localparam logic [11:0] OFS_XSZ   = 12'h0A0;
    localparam logic [11:0] OFS_YSZ   = 12'h0B0;
    localparam logic [11:0] OFS_RT    = 12'h200;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } alias_op_e;

    typedef struct packed {
        logic sys;
        logic mask;
        logic pend;
        logic raw;
        logic frame;
        logic xsz;
        logic ysz;
        logic rt;
    } reg_sel_t;

    typedef struct packed {
        logic [BUS_W-1:0]  frame;
        logic [SIZE_W-1:0] xsize;
        logic [SIZE_W-1:0] ysize;
    } frame_set_t;

    function automatic logic [BUS_W-1:0] alias_apply(
        input alias_op_e        op,
        input logic [BUS_W-1:0] cur,
        input logic [BUS_W-1:0] wd
    );
        case (op)
            OP_SET:    return cur | wd;
            OP_CLEAR:  return cur & ~wd;
            OP_TOGGLE: return cur ^ wd;
            default:   return wd;
        endcase
    endfunction

endpackage

// File: rtl/pfc_decode.sv
module pfc_decode
    import pfc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output alias_op_e         op,
    output reg_sel_t          sel
);
    localparam int LOW_W = 4;

    logic [ADDR_W-1:0] base;

    always_comb begin
        base = {addr[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
        op   = alias_op_e'(addr[3:2]);
        sel.sys   = (base == ADDR_W'(OFS_SYS));
        sel.mask  = (base == ADDR_W'(OFS_MASK));
        sel.pend  = (base == ADDR_W'(OFS_PEND));
        sel.raw   = (base == ADDR_W'(OFS_RAW));
        sel.frame = (base == ADDR_W'(OFS_FRAME));
        sel.xsz   = (base == ADDR_W'(OFS_XSZ));
        sel.ysz   = (base == ADDR_W'(OFS_YSZ));
        sel.rt    = (base == ADDR_W'(OFS_RT));
    end
endmodule

// File: rtl/pfc_alias_reg.sv
module pfc_alias_reg
    import pfc_pkg::*;
#(
    parameter int             W        = 32,
    parameter logic [W-1:0]   RST_VAL  = '0,
    parameter logic [W-1:0]   WMASK    = '1,
    parameter logic [W-1:0]   SELF_CLR = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  alias_op_e    op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] upd;

    always_comb begin
        upd = W'(alias_apply(op, BUS_W'(q), BUS_W'(wdata)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (we) begin
            q <= (upd & WMASK) | (q & ~WMASK);
        end else begin
            q <= q & ~SELF_CLR;
        end
    end
endmodule

// File: rtl/pfc_irq.sv
module pfc_irq
    import pfc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] mask,
    output logic [N-1:0] raw,
    output logic [N-1:0] masked,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst || hold) begin
                raw[i] <= 1'b0;
            end else if (set_evt[i]) begin
                raw[i] <= 1'b1;
            end else if (clr_bits[i]) begin
                raw[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        masked = raw & ~mask;
        irq    = |masked;
    end
endmodule

// File: rtl/pfc_shadow.sv
module pfc_shadow
    import pfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       sh_en,
    input  logic       sw_sel,
    input  logic       sw_trig,
    input  logic       hw_trig,
    input  frame_set_t prog,
    output frame_set_t act,
    output logic       load
);
    always_comb begin
        load = !hold && sh_en && (sw_sel ? sw_trig : hw_trig);
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            act <= '0;
        end else if (load) begin
            act <= prog;
        end
    end
endmodule

// File: rtl/pfc_regs.sv
module pfc_regs
    import pfc_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [7:0]        evt_in,
    input  logic              frame_evt,
    output logic              irq,
    output logic              start_pulse,
    output logic              ctl_repeat,
    output logic              ctl_soft_rst,
    output logic              ctl_master_id,
    output logic [31:0]       act_frame,
    output logic [15:0]       act_xsize,
    output logic [15:0]       act_ysize,
    output logic              rt_abort_sel,
    output logic [2:0]        rt_thr_low,
    output logic [2:0]        rt_thr_high,
    output logic              rt_rows_sel
);
    localparam logic [BUS_W-1:0] RUN_BIT = BUS_W'(1) << SYS_RUN;

    alias_op_e op;
    reg_sel_t  sel;

    logic [BUS_W-1:0]   sys_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] raw_st;
    logic [NUM_SRC-1:0] masked_st;
    logic [RT_W-1:0]    rt_q;
    frame_set_t         prog;
    frame_set_t         act;
    logic               sh_load;
    logic               we_pend;
    logic [NUM_SRC-1:0] set_evt;

    pfc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .op   (op),
        .sel  (sel)
    );

    pfc_alias_reg #(
        .W(BUS_W), .RST_VAL('0), .WMASK(SYS_WMASK), .SELF_CLR(RUN_BIT)
    ) u_sys (
        .clk(clk), .rst(rst), .we(bus_wen && sel.sys), .op(op),
        .wdata(bus_wdata), .q(sys_q)
    );

    pfc_alias_reg #(.W(NUM_SRC), .RST_VAL('1)) u_mask (
        .clk(clk), .rst(rst), .we(bus_wen && sel.mask), .op(op),
        .wdata(bus_wdata[NUM_SRC-1:0]), .q(mask_q)
    );

    pfc_alias_reg #(.W(BUS_W)) u_frame (
        .clk(clk), .rst(rst), .we(bus_wen && sel.frame), .op(op),
        .wdata(bus_wdata), .q(prog.frame)
    );

    pfc_alias_reg #(.W(SIZE_W)) u_xsz (
        .clk(clk), .rst(rst), .we(bus_wen && sel.xsz), .op(op),
        .wdata(bus_wdata[SIZE_W-1:0]), .q(prog.xsize)
    );

    pfc_alias_reg #(.W(SIZE_W)) u_ysz (
        .clk(clk), .rst(rst), .we(bus_wen && sel.ysz), .op(op),
        .wdata(bus_wdata[SIZE_W-1:0]), .q(prog.ysize)
    );

    pfc_alias_reg #(.W(RT_W)) u_rt (
        .clk(clk), .rst(rst), .we(bus_wen && sel.rt), .op(op),
        .wdata(bus_wdata[RT_W-1:0]), .q(rt_q)
    );

    assign start_pulse   = sys_q[SYS_RUN];
    assign ctl_soft_rst  = sys_q[SYS_SRST];
    assign ctl_repeat    = sys_q[SYS_REPEAT];
    assign ctl_master_id = sys_q[SYS_MID];

    pfc_shadow u_shadow (
        .clk     (clk),
        .rst     (rst),
        .hold    (ctl_soft_rst),
        .sh_en   (sys_q[SYS_SHEN]),
        .sw_sel  (sys_q[SYS_SWSEL]),
        .sw_trig (start_pulse),
        .hw_trig (frame_evt),
        .prog    (prog),
        .act     (act),
        .load    (sh_load)
    );

    always_comb begin
        we_pend = bus_wen && sel.pend && (op == OP_WRITE);
        set_evt = evt_in;
        set_evt[ST_RUN]  = evt_in[ST_RUN]  | start_pulse;
        set_evt[ST_SHLD] = evt_in[ST_SHLD] | sh_load;
    end

    pfc_irq #(.N(NUM_SRC)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .hold     (ctl_soft_rst),
        .set_evt  (set_evt),
        .clr_bits (we_pend ? bus_wdata[NUM_SRC-1:0] : '0),
        .mask     (mask_q),
        .raw      (raw_st),
        .masked   (masked_st),
        .irq      (irq)
    );

    assign act_frame    = act.frame;
    assign act_xsize    = act.xsize;
    assign act_ysize    = act.ysize;
    assign rt_abort_sel = rt_q[7];
    assign rt_thr_low   = rt_q[6:4];
    assign rt_thr_high  = rt_q[3:1];
    assign rt_rows_sel  = rt_q[0];

    always_comb begin
        bus_rdata = '0;
        if (sel.sys)   bus_rdata = sys_q;
        if (sel.mask)  bus_rdata = BUS_W'(mask_q);
        if (sel.pend && op == OP_WRITE) bus_rdata = BUS_W'(masked_st);
        if (sel.raw  && op == OP_WRITE) bus_rdata = BUS_W'(raw_st);
        if (sel.frame) bus_rdata = prog.frame;
        if (sel.xsz)   bus_rdata = BUS_W'(prog.xsize);
        if (sel.ysz)   bus_rdata = BUS_W'(prog.ysize);
        if (sel.rt)    bus_rdata = BUS_W'(rt_q);
    end
endmodule

// File: rtl/pfc_regs_chk.sv
module pfc_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_wen,
    input logic [31:0] wd,
    input logic [7:0]  evt_in,
    input logic        we_pend,
    input logic [7:0]  raw,
    input logic        start_pulse,
    input logic        srst,
    input logic        sh_en,
    input logic [31:0] act_frame,
    input logic        irq
);
    AST_RUN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (start_pulse && !bus_wen) |=> !start_pulse); // R4

    AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (rst)
        !srst |=> ((raw & $past(evt_in)) == $past(evt_in))); // R5

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (raw != 8'h00)); // R6

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (we_pend && wd[0] && !evt_in[0]) |=> !raw[0]); // R7

    AST_NO_LOAD_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!sh_en && !srst) |=> $stable(act_frame)); // R9

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        srst |=> (act_frame == 32'h0 && raw == 8'h00)); // R10
endmodule

bind pfc_regs pfc_regs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wen     (bus_wen),
    .wd          (bus_wdata),
    .evt_in      (evt_in),
    .we_pend     (we_pend),
    .raw         (raw_st),
    .start_pulse (start_pulse),
    .srst        (ctl_soft_rst),
    .sh_en       (sys_q[3]),
    .act_frame   (act_frame),
    .irq         (irq)
);

// File: tb/pfc_regs_test.sv
`timescale 1ns/1ps
module pfc_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  evt_in = '0;
    logic        frame_evt = 1'b0;
    logic        irq, start_pulse, ctl_repeat, ctl_soft_rst, ctl_master_id;
    logic [31:0] act_frame;
    logic [15:0] act_xsize, act_ysize;
    logic        rt_abort_sel, rt_rows_sel;
    logic [2:0]  rt_thr_low, rt_thr_high;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pfc_regs #(.ADDR_W(12)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .frame_evt(frame_evt), .irq(irq), .start_pulse(start_pulse),
        .ctl_repeat(ctl_repeat), .ctl_soft_rst(ctl_soft_rst),
        .ctl_master_id(ctl_master_id), .act_frame(act_frame),
        .act_xsize(act_xsize), .act_ysize(act_ysize),
        .rt_abort_sel(rt_abort_sel), .rt_thr_low(rt_thr_low),
        .rt_thr_high(rt_thr_high), .rt_rows_sel(rt_rows_sel)
    );

    typedef struct packed {
        logic [11:0] wa;
        logic [31:0] wd;
        logic [11:0] ra;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{12'h020, 32'h0000_0007, 12'h020, 32'h0000_0007}, // R2 mask replace
        '{12'h024, 32'h0000_0030, 12'h020, 32'h0000_0037}, // R3 set alias
        '{12'h028, 32'h0000_0005, 12'h020, 32'h0000_0032}, // R3 clear alias
        '{12'h02C, 32'h0000_00FF, 12'h020, 32'h0000_00CD}, // R3 toggle alias
        '{12'h0A0, 32'hFFFF_1234, 12'h0A0, 32'h0000_1234}, // R2 width 16 bits
        '{12'h0A4, 32'h0000_8000, 12'h0A8, 32'h0000_9234}, // R3 alias readback
        '{12'h200, 32'hFFFF_FFFF, 12'h200, 32'h0000_00FF}, // R2 line-buffer 8 bits
        '{12'h208, 32'h0000_0081, 12'h200, 32'h0000_007E}, // R3 clear alias
        '{12'h100, 32'h0000_1234, 12'h100, 32'h0000_0000}, // R11 hole
        '{12'h040, 32'h0000_00FF, 12'h040, 32'h0000_0000}, // R11 raw is read-only
        '{12'h070, 32'hABCD_0012, 12'h070, 32'hABCD_0012}, // R2 frame word
        '{12'h0B0, 32'h0000_0438, 12'h0B4, 32'h0000_0438}, // R2 height, R3 alias read
        '{12'h000, 32'hFFFF_FFEC, 12'h000, 32'h0001_000C}, // R2 system writable bits
        '{12'h008, 32'h0001_000C, 12'h000, 32'h0000_0000}  // R3 system clear alias
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wen  = 1'b0;
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_evt(input logic [7:0] e);
        @(negedge clk);
        evt_in = e;
        @(negedge clk);
        evt_in = '0;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_evt = 1'b1;
        @(negedge clk);
        frame_evt = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(12'h000, v); chk("R1", "system", v, 32'h0);
        rd(12'h020, v); chk("R1", "mask", v, 32'hFF);
        rd(12'h040, v); chk("R1", "raw", v, 32'h0);
        rd(12'h200, v); chk("R1", "line-buffer", v, 32'h0);
        chk("R1", "irq/start", {30'h0, irq, start_pulse}, 32'h0);
        chk("R1", "active", act_frame | {act_xsize, act_ysize}, 32'h0);

        // table walk: write then read
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].wa, VECS[i].wd);
            rd(VECS[i].ra, v);
            chk("R2/R3/R11 table", $sformatf("vec %0d", i), v, VECS[i].exp);
        end

        // R12 field outputs: line-buffer holds 0x7E
        chk("R12", "line-buffer fields",
            {24'h0, rt_abort_sel, rt_thr_low, rt_thr_high, rt_rows_sel}, 32'h7E);
        wr(12'h000, 32'h0001_0004);
        #1 chk("R12", "ctl outputs", {29'h0, ctl_master_id, ctl_repeat, ctl_soft_rst},
               32'h6);
        wr(12'h000, 32'h0);

        // R4 run self-clear and start pulse
        wr(12'h000, 32'h1);
        #1;
        chk("R4", "start high", {31'h0, start_pulse}, 32'h1);
        chk("R4", "run reads 1", bus_rdata, 32'h1);
        @(negedge clk); #1;
        chk("R4", "start low", {31'h0, start_pulse}, 32'h0);
        chk("R4", "run reads 0", bus_rdata, 32'h0);
        chk("R6", "irq from run status", {31'h0, irq}, 32'h1);
        rd(12'h040, v); chk("R5", "run status raw", v, 32'h02);
        rd(12'h030, v); chk("R6", "run status masked", v, 32'h02);
        wr(12'h030, 32'h02);
        rd(12'h040, v); chk("R7", "w1c run", v, 32'h0);
        chk("R7", "irq cleared", {31'h0, irq}, 32'h0);

        // R5/R6/R7 events with mask 0xCD
        pulse_evt(8'h81);
        rd(12'h040, v); chk("R5", "raw events", v, 32'h81);
        rd(12'h030, v); chk("R6", "masked hidden", v, 32'h0);
        chk("R6", "irq masked off", {31'h0, irq}, 32'h0);
        wr(12'h028, 32'h80);
        rd(12'h030, v); chk("R6", "masked after unmask", v, 32'h80);
        chk("R6", "irq on", {31'h0, irq}, 32'h1);
        wr(12'h030, 32'h01);
        rd(12'h040, v); chk("R7", "w1c bit0", v, 32'h80);
        wr(12'h030, 32'h00);
        rd(12'h040, v); chk("R7", "zero write", v, 32'h80);
        @(negedge clk);
        bus_addr = 12'h030; bus_wdata = 32'h80; bus_wen = 1'b1; evt_in = 8'h80;
        @(negedge clk);
        bus_wen = 1'b0; evt_in = 8'h00;
        rd(12'h040, v); chk("R7", "event beats clear", v, 32'h80);
        wr(12'h030, 32'h80);
        rd(12'h040, v); chk("R7", "final clear", v, 32'h0);

        // R11 status alias offsets
        pulse_evt(8'h08);
        wr(12'h038, 32'h08);
        rd(12'h040, v); chk("R11", "pend alias write ignored", v, 32'h08);
        rd(12'h034, v); chk("R11", "pend alias read", v, 32'h0);
        wr(12'h030, 32'h08);

        // R8 software shadow mode
        wr(12'h000, 32'h19);
        #1 chk("R8", "not yet loaded", act_frame, 32'h0);
        @(negedge clk); #1;
        chk("R8", "frame loaded", act_frame, 32'hABCD_0012);
        chk("R8", "sizes loaded", {act_xsize, act_ysize}, 32'h9234_0438);
        rd(12'h040, v); chk("R5", "run+shadow status", v, 32'h06);
        wr(12'h070, 32'h1111_1111);
        pulse_frame();
        #1 chk("R8", "frame_evt ignored", act_frame, 32'hABCD_0012);
        wr(12'h030, 32'h06);

        // R9 hardware shadow mode
        wr(12'h008, 32'h10);
        wr(12'h004, 32'h01);
        @(negedge clk); @(negedge clk); #1;
        chk("R9", "run ignored", act_frame, 32'hABCD_0012);
        pulse_frame();
        #1 chk("R9", "frame_evt loads", act_frame, 32'h1111_1111);
        wr(12'h008, 32'h08);
        wr(12'h070, 32'h2222_2222);
        pulse_frame();
        #1 chk("R9", "disabled no load", act_frame, 32'h1111_1111);

        // R10 soft reset
        rd(12'h040, v); chk("R5", "status before srst", v, 32'h06);
        wr(12'h004, 32'h02);
        @(negedge clk); #1;
        chk("R10", "active cleared", act_frame, 32'h0);
        chk("R10", "soft reset out", {31'h0, ctl_soft_rst}, 32'h1);
        rd(12'h040, v); chk("R10", "status cleared", v, 32'h0);
        rd(12'h070, v); chk("R10", "frame kept", v, 32'h2222_2222);
        rd(12'h020, v); chk("R10", "mask kept", v, 32'h4D);
        pulse_evt(8'hFF);
        rd(12'h040, v); chk("R10", "events ignored", v, 32'h0);
        chk("R10", "irq low", {31'h0, irq}, 32'h0);
        wr(12'h008, 32'h02);
        pulse_evt(8'h01);
        rd(12'h040, v); chk("R5", "events after release", v, 32'h01);

        finish_run();
    end
endmodule